// File: doc/BRIEF.md
# Dual-Processor Interrupt Level Controller

This block gathers interrupt requests for a pair of processors, one master and one slave. It turns them into an even-numbered priority level for each processor. Five request kinds feed it. A reset request reaches both processors and cannot be masked. Vertical blank, horizontal blank and audio PWM timer requests arrive as one-cycle trigger pulses. They are latched per processor, but only where that processor enables them. A command request is raised by a host-side two-bit command register.

Each processor owns a 4-bit enable mask and a small set of pending latches. Through a shared write port, selected by `cpu_sel`, a processor programs its mask and acknowledges its own requests by writing to fixed offsets. The host sets the command bits. A processor clears its own command bit through an acknowledge write. The levels go straight to the processors' interrupt-level inputs. The shared horizontal-interrupt enable flag is exported so that the blank timer can use it.

Top module: `irq_level_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high) drives both levels, `cmd_flags` and `hblank_ie` to 0 and clears every mask and pending latch.
- R2: Each level equals twice the index of the highest set bit in that processor's request vector, or 0 when no bit is set. The vector positions are: PWM bit 3, command bit 4, horizontal blank bit 5, vertical blank bit 6, reset bit 7. Only the levels 0, 6, 8, 10, 12 and 14 can appear.
- R3: A `trig_rst` pulse sets a single shared latch that gives both processors bit 7, whatever their masks hold. A write to offset 0x14 with either value of `cpu_sel` clears it.
- R4: A vertical blank, horizontal blank or PWM pulse sets a processor's latch only if that processor's mask bit is 1 in the cycle of the pulse. The mask bits are: bit 3 for vertical blank, bit 2 for horizontal blank, bit 0 for PWM. Clearing the mask bit later leaves an already-latched request in place. A PWM pulse while neither mask has bit 0 set is dropped.
- R5: A processor's command bit is the live AND of its mask bit 1 and its host command bit: bit 0 for the master, bit 1 for the slave. It follows changes to either input.
- R6: A host write (`host_cmd_we`) stores data bits 1..0 in the command register, shown on `cmd_flags`. Higher data bits are ignored.
- R7: Processor writes to offsets 0x16, 0x18 and 0x1c clear the writer's vertical blank, horizontal blank and PWM latch respectively. The other processor's latches are not affected.
- R8: A processor write to offset 0x1a clears the writer's own command-register bit (bit 0 for master, bit 1 for slave), and its command request drops with it.
- R9: A processor write to offset 0x01 stores data bits 3..0 as the writer's mask. Data bit 7 goes to the shared `hblank_ie` flag, and the remaining data bits are ignored.
- R10: When a trigger and an acknowledge hit the same latch in one cycle, the latch ends up set. When a host command write and a 0x1a acknowledge arrive together, the host value is stored.
- R11: The levels are registered. They change one cycle after the pending state, mask or command register they depend on changes.
- R12: Processor writes to any other offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_rst | input | 1 | Shared reset request pulse |
| trig_vblank | input | 1 | Vertical blank request pulse |
| trig_hblank | input | 1 | Horizontal blank request pulse |
| trig_pwm | input | 1 | PWM timer request pulse |
| host_cmd_we | input | 1 | Host command register write strobe |
| host_cmd_wdata | input | DATA_W | Host command write data |
| cpu_sel | input | 1 | Writing processor: 0 master, 1 slave |
| cpu_we | input | 1 | Processor write strobe |
| cpu_addr | input | ADDR_W | Processor write offset |
| cpu_wdata | input | DATA_W | Processor write data |
| lvl_master | output | LVL_W | Registered master interrupt level |
| lvl_slave | output | LVL_W | Registered slave interrupt level |
| cmd_flags | output | 2 | Host command register contents |
| hblank_ie | output | 1 | Shared horizontal interrupt enable flag |

## Verification
The assertions assume that every trigger and write strobe is a clean 0 or 1 on each clock edge. They also assume that `cpu_sel`, `cpu_addr` and the data buses are defined whenever their strobe is high. Triggers may overlap one another and may coincide with acknowledges and host writes; the checks are written for those collisions. The stimulus raises every strobe for exactly one cycle and returns it to 0 before the next operation. The random address mix draws mostly on the defined offsets and sometimes on arbitrary ones, so the ignored-write case gets exercised as well.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
   localparam int unsigned VEC_W   = 8;
   localparam int unsigned POS_PWM = 3;
   localparam int unsigned POS_CMD = 4;
   localparam int unsigned POS_HBL = 5;
   localparam int unsigned POS_VBL = 6;
   localparam int unsigned POS_RST = 7;
   localparam int unsigned MASK_LSB = 3;   // mask bit k lines up with vector bit k+3
   localparam int unsigned NUM_SRC  = 3;   // latched per-processor sources

   typedef logic [VEC_W-1:0] req_vec_t;

   // source index -> request vector position
   function automatic int unsigned src_pos(input int unsigned k);
      case (k)
         0:       return POS_PWM;
         1:       return POS_HBL;
         default: return POS_VBL;
      endcase
   endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned VEC_W = 8,
   parameter int unsigned LVL_W = 4
) (
   input  logic [VEC_W-1:0] vec,
   output logic [LVL_W-1:0] lvl
);
   generate
      if ((2 * (VEC_W - 1)) >= (1 << LVL_W)) begin : g_bad_width
         $error("irq_prio_enc: LVL_W too narrow for VEC_W");
      end
   endgenerate

   always_comb begin
      lvl = '0;
      for (int i = 0; i < int'(VEC_W); i++) begin
         if (vec[i]) lvl = LVL_W'(2 * i);
      end
   end
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice
   import irq_lvl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter logic [ADDR_W-1:0] MASK_OFS = 'h01,
   parameter logic [ADDR_W-1:0] ACK_PWM  = 'h1c,
   parameter logic [ADDR_W-1:0] ACK_HBL  = 'h18,
   parameter logic [ADDR_W-1:0] ACK_VBL  = 'h16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_SRC-1:0] trig,     // {vblank, hblank, pwm}
   input  logic              wr_en,     // write from this processor
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              host_bit,  // this processor's command register bit
   output logic [3:0]        mask_o,
   output req_vec_t          req_o
);
   logic [3:0]         mask_q;
   logic [NUM_SRC-1:0] src_q;

   always_ff @(posedge clk) begin
      if (rst)                            mask_q <= '0;
      else if (wr_en && addr == MASK_OFS) mask_q <= wdata[3:0];
   end

   generate
      for (genvar k = 0; k < int'(NUM_SRC); k++) begin : g_src
         localparam int unsigned POS = src_pos(k);
         localparam logic [ADDR_W-1:0] ACK =
            (k == 0) ? ACK_PWM : ((k == 1) ? ACK_HBL : ACK_VBL);
         logic set_k, clr_k;
         assign set_k = trig[k] && mask_q[POS - MASK_LSB];
         assign clr_k = wr_en && addr == ACK;
         always_ff @(posedge clk) begin
            if (rst)        src_q[k] <= 1'b0;
            else if (set_k) src_q[k] <= 1'b1;   // trigger beats acknowledge
            else if (clr_k) src_q[k] <= 1'b0;
         end
      end
   endgenerate

   always_comb begin
      req_o          = '0;
      req_o[POS_PWM] = src_q[0];
      req_o[POS_HBL] = src_q[1];
      req_o[POS_VBL] = src_q[2];
      req_o[POS_CMD] = mask_q[POS_CMD - MASK_LSB] & host_bit;
   end

   assign mask_o = mask_q;
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
   import irq_lvl_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LVL_W  = 4,
   parameter logic [ADDR_W-1:0] MASK_OFS = 'h01,
   parameter logic [ADDR_W-1:0] ACK_RST  = 'h14,
   parameter logic [ADDR_W-1:0] ACK_VBL  = 'h16,
   parameter logic [ADDR_W-1:0] ACK_HBL  = 'h18,
   parameter logic [ADDR_W-1:0] ACK_CMD  = 'h1a,
   parameter logic [ADDR_W-1:0] ACK_PWM  = 'h1c
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              trig_rst,
   input  logic              trig_vblank,
   input  logic              trig_hblank,
   input  logic              trig_pwm,
   input  logic              host_cmd_we,
   input  logic [DATA_W-1:0] host_cmd_wdata,
   input  logic              cpu_sel,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [LVL_W-1:0]  lvl_master,
   output logic [LVL_W-1:0]  lvl_slave,
   output logic [1:0]        cmd_flags,
   output logic              hblank_ie
);
   localparam int unsigned NUM_CPU = 2;

   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("irq_level_ctrl: DATA_W must be at least 8");
      end
      if (LVL_W < 4) begin : g_bad_lvl
         $error("irq_level_ctrl: LVL_W must be at least 4");
      end
   endgenerate

   logic       rst_pend_q;
   logic [1:0] cmd_q;
   logic       hie_q;
   logic [3:0] mask_q [NUM_CPU];
   req_vec_t   req    [NUM_CPU];
   logic [LVL_W-1:0] lvl_d [NUM_CPU];
   logic [LVL_W-1:0] lvl_q [NUM_CPU];
   logic       pwm_any;
   logic [NUM_SRC-1:0] trig_vec;

   // shared reset request
   always_ff @(posedge clk) begin
      if (rst)                                  rst_pend_q <= 1'b0;
      else if (trig_rst)                        rst_pend_q <= 1'b1;
      else if (cpu_we && cpu_addr == ACK_RST)   rst_pend_q <= 1'b0;
   end

   // host command register: host write wins over a processor acknowledge
   always_ff @(posedge clk) begin
      if (rst)                                  cmd_q <= '0;
      else if (host_cmd_we)                     cmd_q <= host_cmd_wdata[1:0];
      else if (cpu_we && cpu_addr == ACK_CMD)   cmd_q[cpu_sel] <= 1'b0;
   end

   // shared horizontal interrupt enable, written with either mask
   always_ff @(posedge clk) begin
      if (rst)                                  hie_q <= 1'b0;
      else if (cpu_we && cpu_addr == MASK_OFS)  hie_q <= cpu_wdata[7];
   end

   assign pwm_any  = mask_q[0][POS_PWM - MASK_LSB] | mask_q[1][POS_PWM - MASK_LSB];
   assign trig_vec = {trig_vblank, trig_hblank, trig_pwm & pwm_any};

   generate
      for (genvar c = 0; c < int'(NUM_CPU); c++) begin : g_cpu
         req_vec_t full_req;

         irq_cpu_slice #(
            .ADDR_W  (ADDR_W),
            .DATA_W  (DATA_W),
            .MASK_OFS(MASK_OFS),
            .ACK_PWM (ACK_PWM),
            .ACK_HBL (ACK_HBL),
            .ACK_VBL (ACK_VBL)
         ) u_slice (
            .clk     (clk),
            .rst     (rst),
            .trig    (trig_vec),
            .wr_en   (cpu_we && (cpu_sel == 1'(c))),
            .addr    (cpu_addr),
            .wdata   (cpu_wdata),
            .host_bit(cmd_q[c]),
            .mask_o  (mask_q[c]),
            .req_o   (req[c])
         );

         always_comb begin
            full_req          = req[c];
            full_req[POS_RST] = rst_pend_q;
         end

         irq_prio_enc #(
            .VEC_W(VEC_W),
            .LVL_W(LVL_W)
         ) u_enc (
            .vec(full_req),
            .lvl(lvl_d[c])
         );

         always_ff @(posedge clk) begin
            if (rst) lvl_q[c] <= '0;
            else     lvl_q[c] <= lvl_d[c];
         end
      end
   endgenerate

   assign lvl_master = lvl_q[0];
   assign lvl_slave  = lvl_q[1];
   assign cmd_flags  = cmd_q;
   assign hblank_ie  = hie_q;
endmodule

// File: rtl/irq_level_chk.sv
module irq_level_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LVL_W  = 4,
   parameter logic [ADDR_W-1:0] MASK_OFS = 'h01
) (
   input logic              clk,
   input logic              rst,
   input logic              trig_vblank,
   input logic              host_cmd_we,
   input logic [1:0]        host_cmd_lo,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_wdata7,
   input logic [LVL_W-1:0]  lvl_m,
   input logic [LVL_W-1:0]  lvl_s,
   input logic [1:0]        cmd_flags,
   input logic              hblank_ie,
   input logic              rst_pend,
   input logic [3:0]        mask_m
);
   // R2: only even levels from 6 up, or 0
   p_level_legal_r2: assert property (@(posedge clk) disable iff (rst)
      (lvl_m == '0 || (lvl_m >= LVL_W'(6) && !lvl_m[0])) &&
      (lvl_s == '0 || (lvl_s >= LVL_W'(6) && !lvl_s[0])));

   // R3: the shared reset request reaches both processors at top level
   p_rst_shared_r3: assert property (@(posedge clk) disable iff (rst)
      rst_pend |=> (lvl_m == LVL_W'(14) && lvl_s == LVL_W'(14)));

   // R4 / R10: an enabled vertical blank pulse shows up as at least level 12
   p_vbl_latch_r4: assert property (@(posedge clk) disable iff (rst)
      (trig_vblank && mask_m[3]) |=> ##1 (lvl_m >= LVL_W'(12)));

   // R6: host write stores the low two bits
   p_cmd_store_r6: assert property (@(posedge clk) disable iff (rst)
      host_cmd_we |=> (cmd_flags == $past(host_cmd_lo)));

   // R9: mask write copies data bit 7 into the shared flag
   p_hie_store_r9: assert property (@(posedge clk) disable iff (rst)
      (cpu_we && cpu_addr == MASK_OFS) |=> (hblank_ie == $past(cpu_wdata7)));
endmodule

bind irq_level_ctrl irq_level_chk #(
   .ADDR_W  (ADDR_W),
   .LVL_W   (LVL_W),
   .MASK_OFS(MASK_OFS)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .trig_vblank(trig_vblank),
   .host_cmd_we(host_cmd_we),
   .host_cmd_lo(host_cmd_wdata[1:0]),
   .cpu_we     (cpu_we),
   .cpu_addr   (cpu_addr),
   .cpu_wdata7 (cpu_wdata[7]),
   .lvl_m      (lvl_master),
   .lvl_s      (lvl_slave),
   .cmd_flags  (cmd_flags),
   .hblank_ie  (hblank_ie),
   .rst_pend   (rst_pend_q),
   .mask_m     (mask_q[0])
);

// File: tb/irq_level_ctrl_test.sv
module irq_level_ctrl_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst;
   logic       trig_rst, trig_vblank, trig_hblank, trig_pwm;
   logic       host_cmd_we;
   logic [7:0] host_cmd_wdata;
   logic       cpu_sel, cpu_we;
   logic [7:0] cpu_addr, cpu_wdata;
   logic [3:0] lvl_master, lvl_slave;
   logic [1:0] cmd_flags;
   logic       hblank_ie;

   int checks = 0;
   int fails  = 0;

   // reference state
   logic [3:0] m_mask [2];
   logic [7:0] m_pend [2];
   logic       m_rst;
   logic [1:0] m_cmd;
   logic       m_hie;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_level_ctrl uut (
      .clk(clk), .rst(rst),
      .trig_rst(trig_rst), .trig_vblank(trig_vblank),
      .trig_hblank(trig_hblank), .trig_pwm(trig_pwm),
      .host_cmd_we(host_cmd_we), .host_cmd_wdata(host_cmd_wdata),
      .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .lvl_master(lvl_master), .lvl_slave(lvl_slave),
      .cmd_flags(cmd_flags), .hblank_ie(hblank_ie)
   );

   function automatic logic [3:0] exp_lvl(input int c);
      logic [7:0] v;
      v    = m_pend[c];
      v[7] = m_rst;
      v[4] = m_mask[c][1] & m_cmd[c];
      for (int i = 7; i >= 3; i--) if (v[i]) return 4'(2 * i);
      return 4'd0;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int c = 0; c < 2; c++) begin
         m_mask[c] = '0;
         m_pend[c] = '0;
      end
      m_rst = 0; m_cmd = '0; m_hie = 0;
   endtask

   // one operation: strobes high for one cycle; returns at the negedge after it
   task automatic op(input logic tr, tv, th, tp, hw, input logic [7:0] hd,
                     input logic we, sel, input logic [7:0] ad, wd);
      logic [3:0] om [2];
      logic pany;
      om[0] = m_mask[0]; om[1] = m_mask[1];
      pany  = om[0][0] | om[1][0];
      if (tr) m_rst = 1;
      else if (we && ad == 8'h14) m_rst = 0;
      for (int c = 0; c < 2; c++) begin
         logic mine;
         mine = we && (sel == 1'(c));
         if (tv && om[c][3]) m_pend[c][6] = 1;
         else if (mine && ad == 8'h16) m_pend[c][6] = 0;
         if (th && om[c][2]) m_pend[c][5] = 1;
         else if (mine && ad == 8'h18) m_pend[c][5] = 0;
         if (tp && pany && om[c][0]) m_pend[c][3] = 1;
         else if (mine && ad == 8'h1c) m_pend[c][3] = 0;
         if (mine && ad == 8'h01) m_mask[c] = wd[3:0];
      end
      if (we && ad == 8'h01) m_hie = wd[7];
      if (hw) m_cmd = hd[1:0];
      else if (we && ad == 8'h1a) m_cmd[sel] = 0;

      @(negedge clk);
      trig_rst = tr; trig_vblank = tv; trig_hblank = th; trig_pwm = tp;
      host_cmd_we = hw; host_cmd_wdata = hd;
      cpu_we = we; cpu_sel = sel; cpu_addr = ad; cpu_wdata = wd;
      @(negedge clk);
      trig_rst = 0; trig_vblank = 0; trig_hblank = 0; trig_pwm = 0;
      host_cmd_we = 0; cpu_we = 0;
   endtask

   task automatic wr(input logic sel, input logic [7:0] ad, wd);
      op(0, 0, 0, 0, 0, 8'h00, 1, sel, ad, wd);
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1207));
      rst = 1;
      trig_rst = 0; trig_vblank = 0; trig_hblank = 0; trig_pwm = 0;
      host_cmd_we = 0; host_cmd_wdata = '0;
      cpu_sel = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
      model_reset();
      repeat (3) @(negedge clk);
      rst = 0;

      // R1 reset state
      chk("R1 lvl_master", lvl_master, 0);
      chk("R1 lvl_slave", lvl_slave, 0);
      chk("R1 cmd_flags", cmd_flags, 0);
      chk("R1 hblank_ie", hblank_ie, 0);

      // R3 shared reset request, unmaskable, cleared by slave
      op(1, 0, 0, 0, 0, 8'h00, 0, 0, 8'h00, 8'h00);
      settle();
      chk("R3 master sees reset", lvl_master, 14);
      chk("R3 slave sees reset", lvl_slave, 14);
      wr(1, 8'h14, 8'h00);
      settle();
      chk("R3 cleared master", lvl_master, 0);
      chk("R3 cleared slave", lvl_slave, 0);

      // R9 mask and shared flag
      wr(0, 8'h01, 8'h88);
      wr(1, 8'h01, 8'h80);
      chk("R9 hblank_ie set", hblank_ie, 1);

      // R4 vblank latched for master only, survives mask clear
      op(0, 1, 0, 0, 0, 8'h00, 0, 0, 8'h00, 8'h00);
      settle();
      chk("R4 master vblank", lvl_master, 12);
      chk("R4 slave masked", lvl_slave, 0);
      wr(0, 8'h01, 8'h00);
      settle();
      chk("R4 latch kept after mask clear", lvl_master, 12);
      chk("R9 hblank_ie cleared", hblank_ie, 0);

      // R7 acknowledges only touch the writer
      wr(1, 8'h16, 8'h00);
      settle();
      chk("R7 slave ack leaves master", lvl_master, 12);
      wr(0, 8'h16, 8'h00);
      settle();
      chk("R7 master ack clears", lvl_master, 0);

      // R6 / R5 / R11 command path
      op(0, 0, 0, 0, 1, 8'hFF, 0, 0, 8'h00, 8'h00);
      chk("R6 low bits stored", cmd_flags, 3);
      settle();
      chk("R5 masked command", lvl_master, 0);
      wr(0, 8'h01, 8'h02);
      chk("R11 level not yet changed", lvl_master, 0);
      settle();
      chk("R11 level one cycle later", lvl_master, 8);
      chk("R5 slave still masked", lvl_slave, 0);

      // R8 command acknowledge
      wr(0, 8'h1a, 8'h00);
      chk("R8 master bit cleared", cmd_flags, 2);
      settle();
      chk("R8 master command dropped", lvl_master, 0);

      // R10 collisions
      wr(0, 8'h01, 8'h04);
      op(0, 0, 1, 0, 0, 8'h00, 1, 0, 8'h18, 8'h00);
      settle();
      chk("R10 trigger beats ack", lvl_master, 10);
      op(0, 0, 0, 0, 1, 8'h01, 1, 0, 8'h1a, 8'h00);
      chk("R10 host write beats ack", cmd_flags, 1);

      // R12 unused offset
      wr(0, 8'h05, 8'hFF);
      chk("R12 cmd unchanged", cmd_flags, 1);
      chk("R12 hie unchanged", hblank_ie, 0);
      settle();
      chk("R12 level unchanged", lvl_master, 10);

      // R4 PWM enable and drop
      wr(0, 8'h01, 8'h01);
      op(0, 0, 0, 1, 0, 8'h00, 1, 0, 8'h18, 8'h00);
      settle();
      chk("R4 pwm latched", lvl_master, 6);
      wr(0, 8'h01, 8'h00);
      wr(0, 8'h1c, 8'h00);
      op(0, 0, 0, 1, 0, 8'h00, 0, 0, 8'h00, 8'h00);
      wr(0, 8'h01, 8'h01);
      settle();
      chk("R4 pwm dropped when all masked", lvl_master, 0);

      // random mix against the reference
      for (int it = 0; it < 600; it++) begin
         logic [7:0] ad;
         case ($urandom_range(7))
            0: ad = 8'h01; 1: ad = 8'h14; 2: ad = 8'h16; 3: ad = 8'h18;
            4: ad = 8'h1a; 5: ad = 8'h1c; 6: ad = 8'h01;
            default: ad = 8'($urandom);
         endcase
         op(($urandom_range(15) == 0), ($urandom_range(3) == 0),
            ($urandom_range(3) == 0), ($urandom_range(3) == 0),
            ($urandom_range(7) == 0), 8'($urandom),
            ($urandom_range(1) == 1), 1'($urandom), ad, 8'($urandom));
         chk("R6 cmd_flags", cmd_flags, m_cmd);
         chk("R9 hblank_ie", hblank_ie, m_hie);
         settle();
         chk("R2 lvl_master", lvl_master, exp_lvl(0));
         chk("R2 lvl_slave", lvl_slave, exp_lvl(1));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule